// File: doc/BRIEF.md
# Synchronous Burst Read Engine with Group-Crossing Wait States

This block is the read side of a memory array that starts in a plain asynchronous read mode and moves to clocked burst reads once its configuration register is written. Before that write, the data output follows the address input directly. After it, a burst is opened by an address-valid strobe. The engine counts out a programmed initial latency and then delivers one word per rising clock edge from an internal address counter. A ready output tells the host which cycles carry valid data.

The configuration selects one of three burst kinds. The first is an open-ended sequential burst. The other two are fixed bursts of 8 or 16 words that wrap inside their aligned block. The configuration also selects whether ready coincides with each valid word or runs one cycle ahead of it. A sequential burst that does not start on an 8-word boundary pauses at the first crossing into the next group of 8. It pauses for as many cycles as its starting offset inside the group. Dropping chip-enable stops everything at once.

The array content is computed rather than stored: the word at address `a` is `a` zero-extended to the data width, XOR the parameter `SEED` (default 16'hA5C3).

Top module: `burstReadEngine`

## Requirements
- R1: After reset the block is unconfigured. While chip-enable is high, `rdData` equals the word at the present `addr` (combinationally) and `ready` is 1. An address-valid pulse in this state starts no burst.
- R2: While chip-enable is low, `rdData` is 0 and `ready` is 0.
- R3: A cycle with `cfgWrEn` high stores `cfgData` at the rising edge: bits [3:0] are the initial wait count, bits [5:4] the burst kind (00 or 11 sequential, 01 wrap-8, 10 wrap-16), and bit 6 is 1 for early ready. From then on only synchronous reads occur: `rdData` no longer follows `addr`, and `ready` is low outside burst data. The write also abandons any burst in progress.
- R4: If address-valid and chip-enable are high at rising edge E, the address is latched there. The first word is presented after edge E+W, where W is the stored wait count. Counts 0 and 1 act as 2.
- R5: In a sequential burst, each later word appears on the next rising edge, at the next address (plus one, modulo the address range).
- R6: A sequential burst that starts at offset k = addr[2:0], with k nonzero, presents words through the one at offset 7 without gaps. It then shows k cycles with no valid word before the next word. Later group crossings insert nothing.
- R7: With early ready off, `ready` is high exactly in the cycles in which `rdData` holds a burst word. With early ready on, `ready` in a cycle equals word validity in the following cycle. `rdData` does not change in a cycle that carries no new word.
- R8: A wrap-8 (wrap-16) burst presents exactly 8 (16) words with no gaps. The low 3 (4) address bits count up modulo 8 (16) while the upper bits hold. After the last word, `ready` stays low.
- R9: Chip-enable going low ends the burst immediately. Raising it again does not resume the burst; only a new address-valid pulse starts one.
- R10: An address-valid pulse during a burst abandons that burst and starts a new one with its own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address |
| addrValid | input | 1 | Address-valid strobe that opens a burst |
| chipEn | input | 1 | Chip enable, active high |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgData | input | CFG_W | Configuration value (fields in R3) |
| rdData | output | DATA_W | Read data |
| ready | output | 1 | Valid-data indicator |

## Verification
The bench builds the block with its defaults: ADDR_W 12, DATA_W 16 and SEED 16'hA5C3. The 12-bit address gives each test burst a distinct word. The 16-bit data width lets every address map to a word that differs from every other address's word and from zero. With these values a mismatch in address stepping, in wrap arithmetic or in the async/sync switch shows up as a data error. The programmable latency of 2 to 15 lets the bench cover the minimum and clamped counts, the longest group-crossing pause (offset 7 at 9 waits), and early ready on a wrapping burst.

// File: rtl/brePkg.sv
package brePkg;
  localparam int OFS_W = 3;

  localparam int CFG_WAIT_LO = 0;
  localparam int CFG_KIND_LO = 4;
  localparam int CFG_EARLY   = 6;

  typedef enum logic [1:0] {
    WRAP_NONE = 2'd0,
    WRAP_8    = 2'd1,
    WRAP_16   = 2'd2
  } wrapSelT;

  typedef struct packed {
    logic    load;
    logic    step;
    wrapSelT wrapSel;
    logic    syncMode;
  } bStrobeT;
endpackage

// File: rtl/breCtrl.sv
module breCtrl
  import brePkg::*;
#(
  parameter int CFG_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipEn,
  input  logic             addrValid,
  input  logic [OFS_W-1:0] startOfs,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgData,
  input  logic [OFS_W-1:0] curOfs,
  output bStrobeT          strobe,
  output logic             ready
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_STREAM, S_BWAIT} stT;

  localparam int LEN_W = 5;

  stT st, stNext;
  logic cfgDone, earlyCfg, dataValid, validNext;
  logic [3:0] waitCfg, waitCnt, waitEff;
  logic [1:0] kindCfg;
  logic [OFS_W-1:0] bndCnt, pendWait;
  logic [LEN_W-1:0] lenCnt, burstLen;
  logic doLoad, doStep, enterBw, isCont;

  assign isCont   = (kindCfg == 2'd0) || (kindCfg == 2'd3);
  assign burstLen = (kindCfg == 2'd1) ? LEN_W'(8) : LEN_W'(16);
  assign waitEff  = (waitCfg < 4'd2) ? 4'd2 : waitCfg;

  always_comb begin
    stNext    = st;
    validNext = 1'b0;
    doLoad    = 1'b0;
    doStep    = 1'b0;
    enterBw   = 1'b0;
    if (!chipEn || cfgWrEn) begin
      stNext = S_IDLE;
    end else if (addrValid && cfgDone) begin
      stNext = S_WAIT;
      doLoad = 1'b1;
    end else begin
      case (st)
        S_WAIT:   doStep = (waitCnt == 4'd0);
        S_STREAM: doStep = 1'b1;
        S_BWAIT:  if (bndCnt == OFS_W'(1)) stNext = S_STREAM;
        default:  stNext = S_IDLE;
      endcase
      if (doStep) begin
        validNext = 1'b1;
        stNext    = S_STREAM;
        if (!isCont && lenCnt == burstLen - LEN_W'(1)) begin
          stNext = S_IDLE;
        end else if (isCont && pendWait != '0 && curOfs == '1) begin
          stNext  = S_BWAIT;
          enterBw = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= S_IDLE;
      cfgDone   <= 1'b0;
      waitCfg   <= 4'd2;
      kindCfg   <= 2'd0;
      earlyCfg  <= 1'b0;
      dataValid <= 1'b0;
      waitCnt   <= '0;
      bndCnt    <= '0;
      pendWait  <= '0;
      lenCnt    <= '0;
    end else begin
      st        <= stNext;
      dataValid <= validNext;
      if (cfgWrEn) begin
        cfgDone  <= 1'b1;
        waitCfg  <= cfgData[CFG_WAIT_LO +: 4];
        kindCfg  <= cfgData[CFG_KIND_LO +: 2];
        earlyCfg <= cfgData[CFG_EARLY];
      end
      if (doLoad) begin
        waitCnt  <= waitEff - 4'd1;
        pendWait <= isCont ? startOfs : '0;
        lenCnt   <= '0;
      end else if (st == S_WAIT && waitCnt != 4'd0) begin
        waitCnt <= waitCnt - 4'd1;
      end
      if (doStep) lenCnt <= lenCnt + LEN_W'(1);
      if (st == S_BWAIT) bndCnt <= bndCnt - OFS_W'(1);
      if (enterBw) begin
        bndCnt   <= pendWait;
        pendWait <= '0;
      end
    end
  end

  always_comb begin
    strobe.load     = doLoad;
    strobe.step     = doStep;
    strobe.syncMode = cfgDone;
    case (kindCfg)
      2'd1:    strobe.wrapSel = WRAP_8;
      2'd2:    strobe.wrapSel = WRAP_16;
      default: strobe.wrapSel = WRAP_NONE;
    endcase
  end

  assign ready = chipEn & (cfgDone ? (earlyCfg ? validNext : dataValid) : 1'b1);

  // R9: a low chip enable leaves no valid word behind it
  p_ce_off_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |=> !dataValid);
  // R6: a boundary pause carries no valid word after its first cycle
  p_bwait_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_BWAIT) |=> !dataValid);
  // R1: no burst state is reached without a configuration write
  p_no_burst_unconfigured_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgDone |=> (st == S_IDLE));
  // R4: the latency counter never starts above the legal maximum
  p_wait_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    doLoad |=> (waitCnt <= 4'd14));
endmodule

// File: rtl/breDatapath.sv
module breDatapath
  import brePkg::*;
#(
  parameter int              ADDR_W = 12,
  parameter int              DATA_W = 16,
  parameter logic [DATA_W-1:0] SEED = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chipEn,
  input  bStrobeT           strobe,
  output logic [OFS_W-1:0]  curOfs,
  output logic [DATA_W-1:0] rdData
);
  localparam int LO8  = 3;
  localparam int LO16 = 4;

  logic [ADDR_W-1:0] addrCnt, nextAddr;
  logic [DATA_W-1:0] outWord;

  function automatic logic [DATA_W-1:0] wordAt(input logic [ADDR_W-1:0] a);
    return DATA_W'(a) ^ SEED;
  endfunction

  always_comb begin
    case (strobe.wrapSel)
      WRAP_8:  nextAddr = {addrCnt[ADDR_W-1:LO8], addrCnt[LO8-1:0] + LO8'(1)};
      WRAP_16: nextAddr = {addrCnt[ADDR_W-1:LO16], addrCnt[LO16-1:0] + LO16'(1)};
      default: nextAddr = addrCnt + ADDR_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCnt <= '0;
      outWord <= '0;
    end else if (strobe.load) begin
      addrCnt <= addr;
    end else if (strobe.step) begin
      outWord <= wordAt(addrCnt);
      addrCnt <= nextAddr;
    end
  end

  assign curOfs = addrCnt[OFS_W-1:0];
  assign rdData = !chipEn ? '0 : (strobe.syncMode ? outWord : wordAt(addr));

  // R5: a sequential step moves the counter to the next address
  p_seq_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && strobe.wrapSel == WRAP_NONE) |=> (addrCnt == $past(addrCnt) + ADDR_W'(1)));
  // R8: a wrapping step keeps the block-select bits
  p_wrap_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && strobe.wrapSel != WRAP_NONE) |=> (addrCnt[ADDR_W-1:LO16] == $past(addrCnt[ADDR_W-1:LO16])));
  // R7: the output word holds when no word is delivered
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step |=> $stable(outWord));
endmodule

// File: rtl/burstReadEngine.sv
module burstReadEngine
  import brePkg::*;
#(
  parameter int                ADDR_W = 12,
  parameter int                DATA_W = 16,
  parameter int                CFG_W  = 7,
  parameter logic [DATA_W-1:0] SEED   = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addrValid,
  input  logic              chipEn,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgData,
  output logic [DATA_W-1:0] rdData,
  output logic              ready
);
  bStrobeT          strobe;
  logic [OFS_W-1:0] curOfs;

  breCtrl #(.CFG_W(CFG_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipEn   (chipEn),
    .addrValid(addrValid),
    .startOfs (addr[OFS_W-1:0]),
    .cfgWrEn  (cfgWrEn),
    .cfgData  (cfgData),
    .curOfs   (curOfs),
    .strobe   (strobe),
    .ready    (ready)
  );

  breDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED)) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .addr  (addr),
    .chipEn(chipEn),
    .strobe(strobe),
    .curOfs(curOfs),
    .rdData(rdData)
  );
endmodule

// File: tb/test_burstReadEngine.sv
`timescale 1ns/1ps
module test_burstReadEngine;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SEED = 16'hA5C3;

  logic clk = 1'b0, rstN = 1'b0;
  logic [11:0] addr = '0;
  logic addrValid = 1'b0, chipEn = 1'b0, cfgWrEn = 1'b0;
  logic [6:0] cfgData = '0;
  logic [15:0] rdData;
  logic ready;

  burstReadEngine i_burstReadEngine (
    .clk(clk), .rstN(rstN), .addr(addr), .addrValid(addrValid), .chipEn(chipEn),
    .cfgWrEn(cfgWrEn), .cfgData(cfgData), .rdData(rdData), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int c; logic [15:0] d; } expT;
  expT q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit monOn = 0, earlyMode = 0, readyPrev = 0, done = 0;
  int curW = 2, curKind = 0;
  string curTag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] wordAt(input logic [11:0] a);
    return {4'h0, a} ^ SEED;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected words as the design marks them valid
  always @(negedge clk) begin
    if (rstN && monOn) begin
      bit got;
      got = earlyMode ? readyPrev : ready;
      if (got) begin
        if (q.size() == 0) begin
          chk(0, {curTag, " unexpected word"}, rdData, 0);
        end else begin
          expT e;
          e = q.pop_front();
          chk(cyc == e.c, {curTag, " word cycle"}, cyc, e.c);
          chk(rdData == e.d, {curTag, " word data"}, rdData, e.d);
        end
      end
      readyPrev = ready;
    end else begin
      readyPrev = 0;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic waitCyc(input int target);
    while (cyc < target) tick(1);
  endtask

  task automatic writeCfg(input int w, input int kind, input bit early);
    cfgData = {early, 2'(kind), 4'(w)};
    cfgWrEn = 1'b1;
    tick(1);
    cfgWrEn = 1'b0;
    curW = (w < 2) ? 2 : w;
    curKind = kind;
    earlyMode = early;
  endtask

  // driver: pushes the expected words of a burst, then pulses address-valid
  task automatic startBurst(input logic [11:0] a, input int n, output int lastCyc);
    int latch, k;
    latch = cyc + 1;
    k = a[2:0];
    lastCyc = latch;
    for (int j = 0; j < n; j++) begin
      expT e;
      logic [11:0] wa;
      if (curKind == 1)      wa = {a[11:3], 3'(a[2:0] + j)};
      else if (curKind == 2) wa = {a[11:4], 4'(a[3:0] + j)};
      else                   wa = 12'(a + j);
      e.c = latch + curW + j;
      if ((curKind == 0 || curKind == 3) && k != 0 && j >= 8 - k) e.c = e.c + k;
      e.d = wordAt(wa);
      lastCyc = e.c;
      q.push_back(e);
    end
    addr = a;
    addrValid = 1'b1;
    tick(1);
    addrValid = 1'b0;
    addr = 12'hFFF;
  endtask

  task automatic finishBurst(input int lastCyc, input bit dropCe);
    waitCyc(lastCyc + 1);
    if (dropCe) begin
      chipEn = 1'b0;
      tick(3);
      chipEn = 1'b1;
    end
    tick(20);
    chk(q.size() == 0, {curTag, " all words seen"}, q.size(), 0);
  endtask

  initial begin
    int last;
    tick(3);
    rstN = 1'b1;
    tick(1);
    #2;
    chk(rdData == 16'h0, "R2 reset data", rdData, 0);
    chk(ready == 1'b0, "R2 reset ready", ready, 0);

    chipEn = 1'b1; addr = 12'h0F0; #2;
    chk(rdData == wordAt(12'h0F0), "R1 async data", rdData, wordAt(12'h0F0));
    chk(ready == 1'b1, "R1 async ready", ready, 1);
    addrValid = 1'b1; tick(1); addrValid = 1'b0; tick(12);
    addr = 12'h3C7; #2;
    chk(rdData == wordAt(12'h3C7), "R1 no burst before config", rdData, wordAt(12'h3C7));
    chk(ready == 1'b1, "R1 ready stays high", ready, 1);

    chipEn = 1'b0; #2;
    chk(rdData == 16'h0, "R2 disabled data", rdData, 0);
    chk(ready == 1'b0, "R2 disabled ready", ready, 0);
    chipEn = 1'b1;

    writeCfg(9, 0, 0);
    addr = 12'h123; #2;
    chk(rdData == 16'h0, "R3 sync only data", rdData, 0);
    chk(ready == 1'b0, "R3 sync only ready", ready, 0);
    monOn = 1;

    curTag = "R6";
    startBurst(12'h103, 16, last); finishBurst(last, 1);
    startBurst(12'h217, 12, last); finishBurst(last, 1);

    curTag = "R5";
    writeCfg(2, 0, 0);
    startBurst(12'h0A8, 12, last); finishBurst(last, 1);

    curTag = "R4";
    writeCfg(0, 3, 0);
    startBurst(12'h0FD, 12, last); finishBurst(last, 1);

    curTag = "R8";
    writeCfg(3, 2, 0);
    startBurst(12'h2AD, 16, last); finishBurst(last, 0);

    curTag = "R7";
    writeCfg(4, 1, 1);
    startBurst(12'h345, 8, last); finishBurst(last, 0);
    #2;
    chk(ready == 1'b0, "R8 ready low after fixed burst", ready, 0);

    curTag = "R10";
    writeCfg(3, 0, 0);
    startBurst(12'h400, 3, last);
    waitCyc(last);
    startBurst(12'h501, 10, last); finishBurst(last, 1);

    curTag = "R9";
    startBurst(12'h6F0, 4, last);
    finishBurst(last, 1);
    #2;
    chk(ready == 1'b0, "R9 no resume", ready, 0);

    curTag = "R3";
    writeCfg(9, 0, 0);
    startBurst(12'h600, 0, last);
    tick(4);
    writeCfg(9, 0, 0);
    tick(20);
    #2;
    chk(ready == 1'b0, "R3 config write abandons burst", ready, 0);
    chk(q.size() == 0, "R3 no stray words", q.size(), 0);

    monOn = 0;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule